// File: doc/BRIEF.md
# Programmable Clock Output Divider with Staged Source Switch

This block produces a square-wave clock output from one of four source-clock strobes that live in the system clock domain. Each source is a single-cycle enable pulse, one pulse per source period. A small word-addressed register port holds three registers: a staged source choice, an update-enable bit and an integer divider. The selected source strobe is divided by the divider value and drives the output pin.

Writing a new source choice does not move the output at once. The choice waits in a staging register and reaches the active selector only when the update-enable bit is written 0 and then 1. Software confirms that the switch is done by reading the bit back as 1. Whenever the active source or the divider value changes, the divider counter starts again from zero. The first output period after a change is therefore a full one.

Top module: `ckout_gen`

## Requirements
- R1: The source select register at offset 0x0E0 holds a 2-bit field in bits 1:0, where 0 selects `src_tick[0]` (internal RC), 1 `src_tick[1]` (system oscillator), 2 `src_tick[2]` (watchdog oscillator) and 3 `src_tick[3]` (main clock). It resets to 0, and bits 31:2 read as zero.
- R2: Writing the select register changes only the staged value. The source that drives the output stays as it was.
- R3: When bit 0 of the update register (offset 0x0E4) is written as 1 while its stored value is 0, the staged select becomes the active source. The new source is in use from the clock that follows the write.
- R4: The update register reads back its stored bit in bit 0, with all other bits zero, and resets to 0. Writing 1 while the stored bit is already 1 leaves the active source unchanged.
- R5: For a divider value N of 2 or more, the output period is N ticks of the active source. With N = 48 on a source that ticks every clock, the output rises every 48 clocks.
- R6: A divider value of 0 holds the output low.
- R7: A divider value of 1 passes the source through undivided: the output equals the active strobe delayed by one clock.
- R8: A write that changes the divider value, or an update that changes the active source, drives the output low on the next clock and restarts the period count from zero.
- R9: The high phase lasts floor(N/2) ticks and the low phase lasts the remaining ticks. Even N gives a 50% duty cycle, and for odd N the high phase is one tick shorter.
- R10: The divider register at offset 0x0E8 stores bits 7:0, and its upper bits read as zero. Any other address reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_tick | input | 4 | Source clock strobes, one bit per source |
| ck_out | output | 1 | Divided clock output |

## Verification
The bench builds the block with its default parameters: four sources, 8-bit divider and 32-bit data. The four sources tick every 3, 2, 5 and 1 clocks. The different periods make it visible which source is active, so staged, retriggered and applied switches can be told apart by the output period alone. The 8-bit divider lets the bench reach the value 48, the odd and even duty cases, the pass-through and disabled values, and the truncation of a 9-bit write.

// File: rtl/ckout_pkg.sv
package ckout_pkg;

   // Decoded write strobes, one per mapped register.
   typedef struct packed {
      logic sel_wr;
      logic upd_wr;
      logic div_wr;
   } ckout_wstb_t;

   // Names for the source slots.
   typedef enum logic [1:0] {
      SRC_RC   = 2'd0,
      SRC_XTAL = 2'd1,
      SRC_WDOG = 2'd2,
      SRC_MAIN = 2'd3
   } ckout_src_e;

endpackage

// File: rtl/ckout_regs.sv
module ckout_regs
   import ckout_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned SEL_OFS = 'h0E0,
   parameter int unsigned UPD_OFS = 'h0E4,
   parameter int unsigned DIV_OFS = 'h0E8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [SEL_W-1:0]  stage_sel,
   output logic [SEL_W-1:0]  act_sel,
   output logic              upd_bit,
   output logic [DIV_W-1:0]  div_val,
   output logic              restart
);

   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] A_UPD = ADDR_W'(UPD_OFS);
   localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(DIV_OFS);

   ckout_wstb_t            stb;
   logic                   upd_fire;
   logic [DIV_W-1:0]       div_new;

   always_comb begin
      stb        = '0;
      stb.sel_wr = wr_en && (addr == A_SEL);
      stb.upd_wr = wr_en && (addr == A_UPD);
      stb.div_wr = wr_en && (addr == A_DIV);
   end

   assign div_new  = wdata[DIV_W-1:0];
   assign upd_fire = stb.upd_wr && wdata[0] && !upd_bit;
   assign restart  = (upd_fire && (stage_sel != act_sel)) ||
                     (stb.div_wr && (div_new != div_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_sel <= '0;
         act_sel   <= '0;
         upd_bit   <= 1'b0;
         div_val   <= '0;
      end else begin
         if (stb.sel_wr) stage_sel <= wdata[SEL_W-1:0];
         if (stb.upd_wr) upd_bit   <= wdata[0];
         if (upd_fire)   act_sel   <= stage_sel;
         if (stb.div_wr) div_val   <= div_new;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_SEL)      rdata[SEL_W-1:0] = stage_sel;
      else if (addr == A_UPD) rdata[0]         = upd_bit;
      else if (addr == A_DIV) rdata[DIV_W-1:0] = div_val;
   end

endmodule

// File: rtl/ckout_srcmux.sv
module ckout_srcmux #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned SEL_W   = 2
) (
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);

   localparam int unsigned SLOTS = 1 << SEL_W;

   generate
      if (SLOTS == NUM_SRC) begin : g_full
         assign tick = src_tick[sel];
      end else begin : g_sparse
         logic [SLOTS-1:0] padded;
         assign padded = {{(SLOTS-NUM_SRC){1'b0}}, src_tick};
         assign tick   = padded[sel];
      end
   endgenerate

endmodule

// File: rtl/ckout_divider.sv
module ckout_divider #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DIV_W-1:0] div_val,
   input  logic             restart,
   output logic             ck_out
);

   logic [DIV_W-1:0] pos;
   logic [DIV_W-1:0] hi_len;
   logic [DIV_W-1:0] last_pos;

   assign hi_len   = div_val >> 1;
   assign last_pos = div_val - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos    <= '0;
         ck_out <= 1'b0;
      end else if (restart || (div_val == '0)) begin
         pos    <= '0;
         ck_out <= 1'b0;
      end else if (div_val == DIV_W'(1)) begin
         pos    <= '0;
         ck_out <= tick;
      end else if (tick) begin
         ck_out <= (pos < hi_len);
         pos    <= (pos == last_pos) ? '0 : pos + 1'b1;
      end
   end

endmodule

// File: rtl/ckout_gen.sv
module ckout_gen #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned SEL_OFS = 'h0E0,
   parameter int unsigned UPD_OFS = 'h0E4,
   parameter int unsigned DIV_OFS = 'h0E8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               ck_out
);

   localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   initial begin : param_chk
      assert (NUM_SRC >= 2 && DIV_W >= 2 && DIV_W <= DATA_W && SEL_W <= DATA_W)
         else $error("ckout_gen: illegal parameter set");
   end

   logic [SEL_W-1:0] stage_sel;
   logic [SEL_W-1:0] act_sel;
   logic             upd_bit;
   logic [DIV_W-1:0] div_val;
   logic             restart;
   logic             tick;

   ckout_regs #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SEL_W (SEL_W), .DIV_W (DIV_W),
      .SEL_OFS(SEL_OFS), .UPD_OFS(UPD_OFS), .DIV_OFS(DIV_OFS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .stage_sel(stage_sel),
      .act_sel  (act_sel),
      .upd_bit  (upd_bit),
      .div_val  (div_val),
      .restart  (restart)
   );

   ckout_srcmux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .src_tick(src_tick),
      .sel     (act_sel),
      .tick    (tick)
   );

   ckout_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .div_val(div_val),
      .restart(restart),
      .ck_out (ck_out)
   );

endmodule

// File: rtl/ckout_chk.sv
module ckout_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned SEL_OFS = 'h0E0,
   parameter int unsigned UPD_OFS = 'h0E4,
   parameter int unsigned DIV_OFS = 'h0E8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [SEL_W-1:0]  stage_sel,
   input logic [SEL_W-1:0]  act_sel,
   input logic              upd_bit,
   input logic [DIV_W-1:0]  div_val,
   input logic              ck_out
);

   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] A_UPD = ADDR_W'(UPD_OFS);
   localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(DIV_OFS);

   // R1
   sel_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_SEL) |-> (rdata[DATA_W-1:SEL_W] == '0));

   // R2
   sel_write_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SEL) |=> $stable(act_sel));

   // R3
   update_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_UPD && wdata[0] && !upd_bit) |=> (act_sel == $past(stage_sel)));

   // R4
   update_no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_UPD && upd_bit) |=> $stable(act_sel));

   // R6
   div_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val == '0) |=> !ck_out);

   // R8
   div_change_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIV && wdata[DIV_W-1:0] != div_val) |=> !ck_out);

endmodule

bind ckout_gen ckout_chk #(
   .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SEL_W (SEL_W), .DIV_W (DIV_W),
   .SEL_OFS(SEL_OFS), .UPD_OFS(UPD_OFS), .DIV_OFS(DIV_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .stage_sel(stage_sel),
   .act_sel  (act_sel),
   .upd_bit  (upd_bit),
   .div_val  (div_val),
   .ck_out   (ck_out)
);

// File: tb/ckout_gen_test.sv
module ckout_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_SEL = 12'h0E0;
   localparam logic [11:0] A_UPD = 12'h0E4;
   localparam logic [11:0] A_DIV = 12'h0E8;
   localparam logic [11:0] A_BAD = 12'h0EC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  src_tick = '0;
   logic        ck_out;

   int tests = 0;
   int fails = 0;

   ckout_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .src_tick(src_tick), .ck_out(ck_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // Source strobes with periods 3, 2, 5 and 1 clocks.
   initial begin
      int per[4] = '{3, 2, 5, 1};
      int cnt[4] = '{0, 0, 0, 0};
      forever begin
         @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            src_tick[k] = (cnt[k] == 0);
            cnt[k] = (cnt[k] + 1) % per[k];
         end
      end
   end

   // Behavioural reference, compared one step after every rising edge.
   int m_stage, m_upd, m_act, m_div, m_pos, m_out;
   initial begin
      m_stage = 0; m_upd = 0; m_act = 0; m_div = 0; m_pos = 0; m_out = 0;
      forever begin
         @(posedge clk);
         if (!rst_n) begin
            m_stage = 0; m_upd = 0; m_act = 0; m_div = 0; m_pos = 0; m_out = 0;
         end else begin
            int  t;
            bit  chg;
            int  nact;
            int  ndiv;
            t    = src_tick[m_act];
            nact = m_act;
            ndiv = m_div;
            if (wr_en && addr == A_UPD && wdata[0] && m_upd == 0) nact = m_stage;
            if (wr_en && addr == A_DIV) ndiv = wdata & 255;
            chg = (nact != m_act) || (ndiv != m_div);
            if (chg || m_div == 0) begin
               m_pos = 0; m_out = 0;
            end else if (m_div == 1) begin
               m_pos = 0; m_out = t;
            end else if (t != 0) begin
               m_out = (m_pos < m_div / 2) ? 1 : 0;
               m_pos = (m_pos + 1) % m_div;
            end
            if (wr_en && addr == A_SEL) m_stage = wdata & 3;
            if (wr_en && addr == A_UPD) m_upd = wdata & 1;
            m_act = nact;
            m_div = ndiv;
            #1;
            check("R5 per-cycle output", ck_out, m_out);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input int exp);
      @(negedge clk);
      addr = a;
      #1;
      check(req, int'(rdata), exp);
   endtask

   // Measures one full output period and its high phase, in clocks.
   task automatic measure(output int period, output int high);
      int prev;
      int guard;
      period = 0; high = 0; guard = 0;
      @(negedge clk);
      prev = ck_out;
      while (!(prev == 0 && ck_out == 1) && guard < 2000) begin
         prev = ck_out; @(negedge clk); guard++;
      end
      do begin
         period++;
         if (ck_out) high++;
         prev = ck_out;
         @(negedge clk);
      end while (!(prev == 0 && ck_out == 1) && period < 2000);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual expired expected finished");
      finish_run();
   end

   initial begin
      int p, h, ones;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // Reset state
      rd("R1 select reset", A_SEL, 0);
      rd("R4 update reset", A_UPD, 0);
      rd("R10 divider reset", A_DIV, 0);
      check("R6 output low after reset", ck_out, 0);

      // Divider 4 on source 0 (period 3)
      wr(A_DIV, 4);
      measure(p, h);
      check("R5 period div4 src0", p, 12);
      check("R9 high div4 src0", h, 6);

      // Staged select only
      wr(A_SEL, 32'hFFFF_FFF3);
      rd("R1 select readback", A_SEL, 3);
      measure(p, h);
      check("R2 staged select keeps source", p, 12);

      // Update handshake 0 then 1
      wr(A_UPD, 0);
      wr(A_UPD, 1);
      rd("R4 update readback", A_UPD, 1);
      measure(p, h);
      check("R3 switched to src3 period", p, 4);

      // Retrigger attempt
      wr(A_SEL, 1);
      wr(A_UPD, 1);
      measure(p, h);
      check("R4 no retrigger period", p, 4);
      wr(A_UPD, 0);
      wr(A_UPD, 1);
      measure(p, h);
      check("R3 switched to src1 period", p, 8);

      // Back to main clock, divide by 48
      wr(A_SEL, 3);
      wr(A_UPD, 0);
      wr(A_UPD, 1);
      wr(A_DIV, 48);
      check("R8 low after divider change", ck_out, 0);
      measure(p, h);
      check("R5 period div48", p, 48);
      check("R9 high div48", h, 24);

      // Odd divider
      wr(A_DIV, 5);
      measure(p, h);
      check("R9 period div5", p, 5);
      check("R9 high div5", h, 2);

      // Truncated write
      wr(A_DIV, 32'h0000_01FF);
      rd("R10 divider truncated", A_DIV, 255);

      // Pass-through on source 1 (period 2)
      wr(A_SEL, 1);
      wr(A_UPD, 0);
      wr(A_UPD, 1);
      wr(A_DIV, 1);
      repeat (4) @(negedge clk);
      ones = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ck_out) ones++;
      end
      check("R7 pass-through high count", ones, 10);

      // Disabled divider
      wr(A_DIV, 0);
      ones = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ck_out) ones++;
      end
      check("R6 divider zero holds low", ones, 0);

      // Unmapped address
      wr(A_BAD, 32'hFFFF_FFFF);
      rd("R10 unmapped reads zero", A_BAD, 0);
      rd("R10 select untouched", A_SEL, 1);
      rd("R10 divider untouched", A_DIV, 0);
      rd("R10 update untouched", A_UPD, 1);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule